// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block runs on the controller side of a DDR2 memory interface. It takes the memory device from the moment the clock is stable to the point where normal traffic may begin. After reset it keeps the clock enable low and places only no-operation commands on the bus for a long settling interval. It then raises the clock enable and waits a short guard time. After that it steps through a fixed list of commands: a precharge of all banks, and writes to the three extended mode registers and the main mode register, in the order the device requires. A second precharge and two refresh cycles follow, and then a final mode register write that leaves the DLL out of reset.

Every wait is counted in controller clock cycles and set by a parameter. The same holds for the field options that go into each mode register write. Some bits must hold fixed values for initialization to be legal, and the sequencer forces those bits itself. Completion is shown by a level on `init_done`. This level rises only after the last command's spacing has passed and after the DLL has had its lock interval since it was reset. A synchronous active-low reset, applied at any point, returns the block to the clock-enable-low hold.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its start state: `cke` low, a NOP on the bus and `init_done` low. It does so from any point in the sequence, including after completion.
- R2: For the first T_PWRUP cycles after reset is released, `cke` stays low and every command is a NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1). After those cycles `cke` goes high.
- R3: Once `cke` has gone high, it stays high until the next reset.
- R4: Exactly T_CKE_WAIT cycles after `cke` rises, a precharge-all is issued: ras_n=0, cas_n=1, we_n=0, addr bit 10 set, all other address bits and ba zero.
- R5: Mode register writes (ras_n=0, cas_n=0, we_n=0) follow in this order, selected by bank address: ba=2, then ba=3, then ba=1, then ba=0. The ba=2 and ba=3 writes carry their option parameters on addr.
- R6: The ba=1 write carries EMR1_OPTS with addr bit 0 and addr bits 9..7 forced to zero.
- R7: The first ba=0 write carries MR_OPTS with addr bit 8 forced to one (DLL reset). The final ba=0 write carries MR_OPTS with addr bit 8 forced to zero.
- R8: After the DLL-reset write come, in order: a precharge-all, two refresh commands (ras_n=0, cas_n=0, we_n=1, addr and ba zero), and then the final mode register write.
- R9: Consecutive commands are spaced exactly T_MRD cycles after a mode write, T_RP after a precharge and T_RFC after a refresh. Only NOPs appear in between.
- R10: `init_done` rises at the later of two points: T_MRD cycles after the final mode write, or DLL_LOCK cycles after the DLL-reset write. Once high, it stays high until reset and only appears with `cke` high.
- R11: `odt` is low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address; selects which mode register a write targets |
| addr | output | ROW_W | Address bus; carries the mode register contents |
| odt | output | 1 | On-die termination control, held low |
| init_done | output | 1 | High once the device is ready for use |

## Verification
The bench drives two copies of the block. Both use short waits; one has a DLL lock count one cycle longer than the command sequence, and the other has a lock count well inside it. This way both arms of the completion rule are hit, and a design that waits on only one condition asserts `init_done` a cycle early or late in one of the copies. Every cycle is compared against an arithmetically computed timeline, so an off-by-one wait, a swapped bank address or a forced mode bit left unforced shows up as a mismatch on a named cycle. Reset is applied both mid-sequence and after completion; a design that restarts from the wrong state, or leaves `cke` or `init_done` high, then diverges from the replayed timeline.

// File: rtl/ddr2_init_pkg.sv
// Package ddr2_init_pkg
// Shared types and constants for the DDR2 initialization sequencer.
// Assumes commands are encoded on {ras_n, cas_n, we_n} with cs_n low.
package ddr2_init_pkg;

    // Sequence steps, in the order they are visited.
    typedef enum logic [3:0] {
        ST_HOLD  = 4'd0,
        ST_CKEW  = 4'd1,
        ST_PRE1  = 4'd2,
        ST_EMR2  = 4'd3,
        ST_EMR3  = 4'd4,
        ST_EMR1  = 4'd5,
        ST_MRDLL = 4'd6,
        ST_PRE2  = 4'd7,
        ST_REF1  = 4'd8,
        ST_REF2  = 4'd9,
        ST_MRFIN = 4'd10,
        ST_DONE  = 4'd11
    } step_t;

    // Command codes on {ras_n, cas_n, we_n}.
    localparam logic [2:0] CMD_NOP  = 3'b111;
    localparam logic [2:0] CMD_PRE  = 3'b010;
    localparam logic [2:0] CMD_LM   = 3'b000;
    localparam logic [2:0] CMD_REF  = 3'b001;

    // Address bit that selects all banks on a precharge.
    localparam int PRE_ALL_BIT = 10;
    // Address bit that resets the DLL in the main mode register.
    localparam int DLL_RST_BIT = 8;

endpackage

// File: rtl/init_step_timer.sv
// Module init_step_timer
// Counts the cycles spent in the current sequence step. The count restarts
// at zero on clear and stops at limit-1, where 'last' is raised.
// Assumes limit >= 1 and that limit does not change between clears.
module init_step_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    // Final cycle of the step is reached when the count meets limit-1.
    assign last = (count == (limit - CNT_W'(1)));

    // Step-local cycle counter, saturating on its final value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (!last) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/init_lock_counter.sv
// Module init_lock_counter
// Measures the DLL lock interval. A start pulse arms it; 'expired' rises
// LOCK_CYC cycles after the cycle that carried the pulse and stays high
// until reset. Assumes LOCK_CYC >= 1.
module init_lock_counter #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);

    localparam int LW = $clog2(LOCK_CYC + 1);

    logic [LW-1:0] elapsed;
    logic          armed;

    assign expired = (elapsed == LW'(LOCK_CYC));

    // Arm on start and count up to the lock interval, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
            armed   <= 1'b0;
        end else begin
            armed <= armed | start;
            if ((armed || start) && !expired) begin
                elapsed <= elapsed + LW'(1);
            end
        end
    end

endmodule

// File: rtl/init_cmd_encode.sv
// Module init_cmd_encode
// Turns the current step into command pins, bank address and address.
// A command is placed on the bus only in the first cycle of its step;
// all other cycles carry a NOP. Forced mode bits are applied here.
// Assumes ROW_W >= 11 and BANK_W >= 2.
module init_cmd_encode
    import ddr2_init_pkg::*;
#(
    parameter int               ROW_W     = 14,
    parameter int               BANK_W    = 3,
    parameter logic [ROW_W-1:0] MR_OPTS   = '0,
    parameter logic [ROW_W-1:0] EMR1_OPTS = '0,
    parameter logic [ROW_W-1:0] EMR2_OPTS = '0,
    parameter logic [ROW_W-1:0] EMR3_OPTS = '0
) (
    input  step_t              step,
    input  logic               first,
    output logic               cs_n,
    output logic               ras_n,
    output logic               cas_n,
    output logic               we_n,
    output logic [BANK_W-1:0]  ba,
    output logic [ROW_W-1:0]   addr
);

    localparam logic [ROW_W-1:0] PRE_ADDR  = ROW_W'(1) << PRE_ALL_BIT;
    localparam logic [ROW_W-1:0] DLL_MASK  = ROW_W'(1) << DLL_RST_BIT;
    localparam logic [ROW_W-1:0] EMR1_CLR  = ROW_W'(10'h381);
    localparam logic [ROW_W-1:0] EMR1_WORD = EMR1_OPTS & ~EMR1_CLR;
    localparam logic [ROW_W-1:0] MR_RESET  = MR_OPTS | DLL_MASK;
    localparam logic [ROW_W-1:0] MR_FINAL  = MR_OPTS & ~DLL_MASK;

    logic [2:0] code;

    assign cs_n = 1'b0;
    assign {ras_n, cas_n, we_n} = code;

    // Select command code, bank and address for the current step.
    always_comb begin
        code = CMD_NOP;
        ba   = '0;
        addr = '0;
        if (first) begin
            case (step)
                ST_PRE1, ST_PRE2: begin
                    code = CMD_PRE;
                    addr = PRE_ADDR;
                end
                ST_EMR2: begin
                    code = CMD_LM;
                    ba   = BANK_W'(2);
                    addr = EMR2_OPTS;
                end
                ST_EMR3: begin
                    code = CMD_LM;
                    ba   = BANK_W'(3);
                    addr = EMR3_OPTS;
                end
                ST_EMR1: begin
                    code = CMD_LM;
                    ba   = BANK_W'(1);
                    addr = EMR1_WORD;
                end
                ST_MRDLL: begin
                    code = CMD_LM;
                    addr = MR_RESET;
                end
                ST_MRFIN: begin
                    code = CMD_LM;
                    addr = MR_FINAL;
                end
                ST_REF1, ST_REF2: begin
                    code = CMD_REF;
                end
                default: begin
                    code = CMD_NOP;
                end
            endcase
        end
    end

endmodule

// File: rtl/ddr2_init_seq.sv
// Module ddr2_init_seq
// Top of the DDR2 power-up initialization sequencer. Walks a fixed list of
// steps; each step lasts a parameterized number of cycles, and a command,
// if any, goes out in the step's first cycle. Completion waits on both
// the end of the list and the DLL lock interval.
// Assumes a stable clock before reset is released and all waits >= 1.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int               ROW_W      = 14,
    parameter int               BANK_W     = 3,
    parameter int               T_PWRUP    = 40000,
    parameter int               T_CKE_WAIT = 80,
    parameter int               T_MRD      = 2,
    parameter int               T_RP       = 3,
    parameter int               T_RFC      = 26,
    parameter int               DLL_LOCK   = 200,
    parameter logic [ROW_W-1:0] MR_OPTS    = '0,
    parameter logic [ROW_W-1:0] EMR1_OPTS  = '0,
    parameter logic [ROW_W-1:0] EMR2_OPTS  = '0,
    parameter logic [ROW_W-1:0] EMR3_OPTS  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic              odt,
    output logic              init_done
);

    localparam int MAX_AB  = (T_PWRUP > T_CKE_WAIT) ? T_PWRUP : T_CKE_WAIT;
    localparam int MAX_CD  = (T_MRD > T_RP) ? T_MRD : T_RP;
    localparam int MAX_ABC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int MAX_GAP = (MAX_ABC > T_RFC) ? MAX_ABC : T_RFC;
    localparam int CNT_W   = $clog2(MAX_GAP) + 1;

    step_t            step_q;
    step_t            step_d;
    logic [CNT_W-1:0] gap_len;
    logic [CNT_W-1:0] step_cnt;
    logic             step_last;
    logic             advance;
    logic             first;
    logic             dll_start;
    logic             lock_ok;

    // Length of each step in cycles.
    always_comb begin
        case (step_q)
            ST_HOLD:                   gap_len = CNT_W'(T_PWRUP);
            ST_CKEW:                   gap_len = CNT_W'(T_CKE_WAIT);
            ST_PRE1, ST_PRE2:          gap_len = CNT_W'(T_RP);
            ST_REF1, ST_REF2:          gap_len = CNT_W'(T_RFC);
            ST_EMR2, ST_EMR3, ST_EMR1,
            ST_MRDLL, ST_MRFIN:        gap_len = CNT_W'(T_MRD);
            default:                   gap_len = CNT_W'(1);
        endcase
    end

    assign advance   = step_last && (step_q != ST_DONE);
    assign first     = (step_cnt == '0);
    assign dll_start = (step_q == ST_MRDLL) && first;

    // Next step follows the fixed order; the final step is held.
    always_comb begin
        step_d = advance ? step_t'(4'(step_q) + 4'd1) : step_q;
    end

    // Step register with synchronous active-low reset to the hold step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_HOLD;
        end else begin
            step_q <= step_d;
        end
    end

    init_step_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (advance),
        .limit (gap_len),
        .count (step_cnt),
        .last  (step_last)
    );

    init_lock_counter #(
        .LOCK_CYC (DLL_LOCK)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (dll_start),
        .expired (lock_ok)
    );

    init_cmd_encode #(
        .ROW_W     (ROW_W),
        .BANK_W    (BANK_W),
        .MR_OPTS   (MR_OPTS),
        .EMR1_OPTS (EMR1_OPTS),
        .EMR2_OPTS (EMR2_OPTS),
        .EMR3_OPTS (EMR3_OPTS)
    ) u_enc (
        .step  (step_q),
        .first (first),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr)
    );

    assign cke       = (step_q != ST_HOLD);
    assign odt       = 1'b0;
    assign init_done = (step_q == ST_DONE) && lock_ok;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
// Module ddr2_init_seq_chk
// Protocol checker for ddr2_init_seq, attached by bind. Watches the bus
// only: command spacing, clock-enable behaviour, forced mode bits and the
// completion condition. Windows are measured with counters, not delays.
module ddr2_init_seq_chk #(
    parameter int ROW_W    = 14,
    parameter int BANK_W   = 3,
    parameter int T_MRD    = 2,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 26,
    parameter int DLL_LOCK = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] ba,
    input logic [ROW_W-1:0]  addr,
    input logic              init_done
);

    localparam int unsigned SAT = 32'd1_000_000;

    logic        is_nop;
    logic        is_pre;
    logic        is_lm;
    logic        is_ref;
    logic        dll_write;
    int unsigned since_cmd;
    int unsigned need_gap;
    int unsigned since_dll;
    logic        dll_seen;

    assign is_nop    = cs_n || (ras_n && cas_n && we_n);
    assign is_pre    = !cs_n && !ras_n &&  cas_n && !we_n;
    assign is_lm     = !cs_n && !ras_n && !cas_n && !we_n;
    assign is_ref    = !cs_n && !ras_n && !cas_n &&  we_n;
    assign dll_write = is_lm && (ba == '0) && addr[8];

    // Cycles since the last command and the spacing that command demands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cmd <= 0;
            need_gap  <= 0;
        end else if (!is_nop) begin
            since_cmd <= 1;
            need_gap  <= is_pre ? T_RP : (is_ref ? T_RFC : T_MRD);
        end else if (since_cmd < SAT) begin
            since_cmd <= since_cmd + 1;
        end
    end

    // Cycles since the DLL-reset mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_dll <= 0;
            dll_seen  <= 1'b0;
        end else if (dll_write) begin
            since_dll <= 1;
            dll_seen  <= 1'b1;
        end else if (dll_seen && since_dll < SAT) begin
            since_dll <= since_dll + 1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!cke && !init_done));

    assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> is_nop);

    assert_cke_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    assert_pre_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (addr[10] && ba == '0));

    assert_emr1_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lm && ba == BANK_W'(1)) |-> (!addr[0] && addr[9:7] == 3'b000));

    assert_ref_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (addr == '0 && ba == '0));

    assert_cmd_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |-> (since_cmd >= need_gap));

    assert_done_after_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (dll_seen && since_dll >= DLL_LOCK));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_cke_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> cke);

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
    .ROW_W    (ROW_W),
    .BANK_W   (BANK_W),
    .T_MRD    (T_MRD),
    .T_RP     (T_RP),
    .T_RFC    (T_RFC),
    .DLL_LOCK (DLL_LOCK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/ddr2_init_seq_tb.sv
`timescale 1ns/1ps
// Bench for ddr2_init_seq: two copies with short waits, one where the DLL
// lock count outlasts the sequence and one where it does not. Every cycle
// is compared against a timeline computed from the parameters.
module ddr2_init_seq_tb;

    localparam int P      = 40;
    localparam int W      = 5;
    localparam int MRD    = 2;
    localparam int RP     = 3;
    localparam int RFC    = 6;
    localparam int LOCK_A = 20;
    localparam int LOCK_B = 8;

    localparam logic [13:0] MR_O   = 14'h0142;
    localparam logic [13:0] EMR1_O = 14'h03C5;
    localparam logic [13:0] EMR2_O = 14'h0080;
    localparam logic [13:0] EMR3_O = 14'h0000;

    localparam int T_PRE1 = P + W;
    localparam int T_EMR2 = T_PRE1 + RP;
    localparam int T_EMR3 = T_EMR2 + MRD;
    localparam int T_EMR1 = T_EMR3 + MRD;
    localparam int T_DLL  = T_EMR1 + MRD;
    localparam int T_PRE2 = T_DLL + MRD;
    localparam int T_REF1 = T_PRE2 + RP;
    localparam int T_REF2 = T_REF1 + RFC;
    localparam int T_MRF  = T_REF2 + RFC;
    localparam int T_END  = T_MRF + MRD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        a_cke, a_cs, a_ras, a_cas, a_we, a_odt, a_done;
    logic [2:0]  a_ba;
    logic [13:0] a_addr;
    logic        b_cke, b_cs, b_ras, b_cas, b_we, b_odt, b_done;
    logic [2:0]  b_ba;
    logic [13:0] b_addr;

    int k = 0;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    ddr2_init_seq #(
        .ROW_W(14), .BANK_W(3), .T_PWRUP(P), .T_CKE_WAIT(W), .T_MRD(MRD),
        .T_RP(RP), .T_RFC(RFC), .DLL_LOCK(LOCK_A), .MR_OPTS(MR_O),
        .EMR1_OPTS(EMR1_O), .EMR2_OPTS(EMR2_O), .EMR3_OPTS(EMR3_O)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras),
        .cas_n(a_cas), .we_n(a_we), .ba(a_ba), .addr(a_addr), .odt(a_odt),
        .init_done(a_done)
    );

    ddr2_init_seq #(
        .ROW_W(14), .BANK_W(3), .T_PWRUP(P), .T_CKE_WAIT(W), .T_MRD(MRD),
        .T_RP(RP), .T_RFC(RFC), .DLL_LOCK(LOCK_B), .MR_OPTS(MR_O),
        .EMR1_OPTS(EMR1_O), .EMR2_OPTS(EMR2_O), .EMR3_OPTS(EMR3_O)
    ) u_dut_b (
        .clk(clk), .rst_n(rst_n), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras),
        .cas_n(b_cas), .we_n(b_we), .ba(b_ba), .addr(b_addr), .odt(b_odt),
        .init_done(b_done)
    );

    // Packed bus {cs_n, ras_n, cas_n, we_n, ba, addr} expected at index n.
    function automatic logic [20:0] exp_bus(int n);
        case (n)
            T_PRE1, T_PRE2: exp_bus = {4'b0010, 3'd0, 14'h0400};
            T_EMR2:         exp_bus = {4'b0000, 3'd2, EMR2_O};
            T_EMR3:         exp_bus = {4'b0000, 3'd3, EMR3_O};
            T_EMR1:         exp_bus = {4'b0000, 3'd1, EMR1_O & ~14'h0381};
            T_DLL:          exp_bus = {4'b0000, 3'd0, MR_O | 14'h0100};
            T_MRF:          exp_bus = {4'b0000, 3'd0, MR_O & ~14'h0100};
            T_REF1, T_REF2: exp_bus = {4'b0001, 3'd0, 14'h0000};
            default:        exp_bus = {4'b0111, 3'd0, 14'h0000};
        endcase
    endfunction

    // Requirement that governs the bus at index n.
    function automatic string bus_tag(int n, bit in_rst);
        if (in_rst)                          bus_tag = "R1";
        else if (n == T_PRE1)                bus_tag = "R4";
        else if (n == T_EMR2 || n == T_EMR3) bus_tag = "R5";
        else if (n == T_EMR1)                bus_tag = "R6";
        else if (n == T_DLL || n == T_MRF)   bus_tag = "R7";
        else if (n == T_PRE2 || n == T_REF1 || n == T_REF2) bus_tag = "R8";
        else if (n < P)                      bus_tag = "R2";
        else                                 bus_tag = "R9";
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at k=%0d: actual=%h expected=%h", tag, what, k, act, exp);
        end
    endtask

    task automatic check_one(string who, int lock, bit in_rst, logic cke, logic cs,
                             logic ras, logic cas, logic we, logic [2:0] ba,
                             logic [13:0] addr, logic odt, logic done);
        int done_at;
        done_at = (T_END > T_DLL + lock) ? T_END : T_DLL + lock;
        chk(in_rst ? "R1" : (k < P ? "R2" : "R3"), {who, " cke"},
            32'(cke), 32'(k >= P));
        chk(bus_tag(k, in_rst), {who, " bus"},
            32'({cs, ras, cas, we, ba, addr}), 32'(exp_bus(k)));
        chk(in_rst ? "R1" : "R10", {who, " init_done"},
            32'(done), 32'(k >= done_at));
        chk("R11", {who, " odt"}, 32'(odt), 32'd0);
    endtask

    // One clock: count the edge if reset was released, then sample mid-cycle.
    task automatic tick();
        bit in_rst;
        @(posedge clk);
        in_rst = !rst_n;
        if (rst_n) k++;
        #2;
        check_one("A", LOCK_A, in_rst, a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_odt, a_done);
        check_one("B", LOCK_B, in_rst, b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_odt, b_done);
    endtask

    task automatic apply_reset(int cycles);
        rst_n = 1'b0;
        k = 0;
        repeat (cycles) tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #1;
        // R1: reset from power-on.
        apply_reset(3);
        // Full sequence, well past both completion points.
        repeat (T_END + LOCK_A + 10) tick();
        // R1: reset after completion, then a partial run.
        apply_reset(2);
        repeat (T_REF1 + 1) tick();
        // R1: reset in the middle of the refresh phase, then a full rerun.
        apply_reset(2);
        repeat (T_END + LOCK_A + 10) tick();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule